// File: doc/BRIEF.md
# Integer ALU with Branch Flags

This block is the integer arithmetic-logic unit of an in-order pipeline's execute stage. It takes two operands and a five-bit operation code, and returns one result word and a three-bit flag vector that an external branch comparator uses. Both outputs are registered. An operation presented in one cycle appears on the outputs after the next rising clock edge.

The operation code is packed as {word, alt, funct3}. The low three bits carry the instruction's funct3 field. The alt bit picks the alternate form: subtract instead of add, arithmetic instead of logical right shift, and pass-B instead of OR. The word bit applies only when the data width is 64. It runs the operation on the low 32 bits of the operands and sign-extends the 32-bit answer. The flags always compare the full-width operands, whatever operation is selected.

Top module: `int_alu`

## Requirements
- R1: Code 5'b00000 gives A+B modulo 2^XLEN on `result` one clock edge after the inputs are presented.
- R2: Code 5'b01000 gives A-B modulo 2^XLEN.
- R3: Code 5'b01110 gives operand B unchanged (load-upper-immediate). It is not treated as OR.
- R4: funct3 001 shifts A left logically. funct3 101 shifts A right, arithmetically when alt=1 and logically when alt=0. The shift amount is B[5:0] for 64-bit operations and B[4:0] for 32-bit and word operations.
- R5: funct3 010 gives the signed A<B comparison and funct3 011 gives the unsigned one. The comparison sits in bit 0 and all other result bits are zero.
- R6: funct3 100 gives A XOR B, funct3 110 with alt=0 gives A OR B, and funct3 111 gives A AND B.
- R7: With XLEN=64 and word bit (bit 4) set, the operation uses A[31:0] and B[31:0], and the 32-bit answer is sign-extended from its bit 31.
- R8: `flags` is {eq, lt, ltu} in bits 2, 1, 0: A==B, signed A<B, unsigned A<B. The flags use the full-width operands for every operation code and are registered like `result`.
- R9: A synchronous active-high `rst` clears `result` and `flags` to zero.
- R10: The alt bit (bit 3) has no effect for funct3 001, 010, 011, 100 and 111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | XLEN | Operand A |
| op_b | input | XLEN | Operand B |
| op_code | input | 5 | Operation code {word, alt, funct3} |
| result | output | XLEN | Registered operation result |
| flags | output | 3 | Registered {eq, lt, ltu} of the full operands |

## Verification
Some properties are checked on every cycle against the registered outputs:
- the reset value;
- pass-B reproducing the previous cycle's operand B;
- set-less-than leaving every bit above bit 0 clear;
- word results being sign-extended;
- the eq flag following operand equality;
- eq never coinciding with a less-than flag;
- addition matching the previous operands.

Only the bench's scenarios show the rest:
- the exact shift amounts, including amounts that wrap beyond the mask width;
- the signed-versus-unsigned split at the sign boundary;
- the alt bit being ignored where it has no meaning;
- agreement with a reference model over random codes and operands.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [2:0] {
    F3_ADD  = 3'b000,
    F3_SLL  = 3'b001,
    F3_SLT  = 3'b010,
    F3_SLTU = 3'b011,
    F3_XOR  = 3'b100,
    F3_SR   = 3'b101,
    F3_OR   = 3'b110,
    F3_AND  = 3'b111
  } alu_f3_e;

  typedef struct packed {
    logic    word;
    logic    alt;
    alu_f3_e f3;
  } alu_code_t;

  localparam int CODE_W = $bits(alu_code_t);

endpackage

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [2:0]   flg
);
  logic eq, lt_s, lt_u;

  always_comb begin
    eq   = (a == b);
    lt_u = (a < b);
    // signed compare: differing signs decide, else unsigned order
    lt_s = (a[W-1] != b[W-1]) ? a[W-1] : lt_u;
    flg  = {eq, lt_s, lt_u};
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         alt,
  input  alu_f3_e      f3,
  output logic [W-1:0] y
);
  localparam int SHW = $clog2(W);

  logic         sub_en;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;
  logic [SHW-1:0] shamt;
  logic [W-1:0] shl, shr_l, shr_a;
  logic         lt_s, lt_u;

  always_comb begin
    sub_en = alt && (f3 == F3_ADD);
    b_eff  = sub_en ? ~b : b;
    sum    = a + b_eff + {{(W-1){1'b0}}, sub_en};
    shamt  = b[SHW-1:0];
    shl    = a << shamt;
    shr_l  = a >> shamt;
    shr_a  = W'($signed(a) >>> shamt);
    lt_u   = (a < b);
    lt_s   = (a[W-1] != b[W-1]) ? a[W-1] : lt_u;
  end

  always_comb begin
    unique case (f3)
      F3_ADD:  y = sum;
      F3_SLL:  y = shl;
      F3_SLT:  y = {{(W-1){1'b0}}, lt_s};
      F3_SLTU: y = {{(W-1){1'b0}}, lt_u};
      F3_XOR:  y = a ^ b;
      F3_SR:   y = alt ? shr_a : shr_l;
      F3_OR:   y = alt ? b : (a | b);
      F3_AND:  y = a & b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [4:0]      op_code,
  output logic [XLEN-1:0] result,
  output logic [2:0]      flags
);
  alu_code_t       code;
  logic [XLEN-1:0] y_full;
  logic [XLEN-1:0] y_next;
  logic [2:0]      flg_next;

  assign code = alu_code_t'(op_code);

  alu_core #(.W(XLEN)) u_core_full (
    .a   (op_a),
    .b   (op_b),
    .alt (code.alt),
    .f3  (code.f3),
    .y   (y_full)
  );

  alu_flags #(.W(XLEN)) u_flags (
    .a   (op_a),
    .b   (op_b),
    .flg (flg_next)
  );

  generate
    if (XLEN == 64) begin : g_word
      logic [31:0] y_word;

      alu_core #(.W(32)) u_core_word (
        .a   (op_a[31:0]),
        .b   (op_b[31:0]),
        .alt (code.alt),
        .f3  (code.f3),
        .y   (y_word)
      );

      assign y_next = code.word ? {{(XLEN-32){y_word[31]}}, y_word} : y_full;

      AST_WORD_SEXT: assert property (@(posedge clk) disable iff (rst)
        (code.word) |=> (result[XLEN-1:32] == {(XLEN-32){result[31]}})) // R7
        else $error("word result not sign-extended");
    end else begin : g_noword
      assign y_next = y_full;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      flags  <= '0;
    end else begin
      result <= y_next;
      flags  <= flg_next;
    end
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (result == '0 && flags == 3'b000)) // R9
    else $error("outputs not cleared by reset");

  AST_PASS_B: assert property (@(posedge clk) disable iff (rst)
    (op_code == 5'b01110) |=> (result == $past(op_b))) // R3
    else $error("pass-B mismatch");

  AST_ADD: assert property (@(posedge clk) disable iff (rst)
    (op_code == 5'b00000) |=> (result == $past(op_a) + $past(op_b))) // R1
    else $error("add mismatch");

  AST_SLT_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (code.f3 == F3_SLT || code.f3 == F3_SLTU) |=> (result[XLEN-1:1] == '0)) // R5
    else $error("set-less-than upper bits nonzero");

  AST_FLAG_EQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (flags[2] == ($past(op_a) == $past(op_b)))) // R8
    else $error("eq flag mismatch");

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    flags[2] |-> (flags[1:0] == 2'b00)) // R8
    else $error("eq flag with less-than flag");

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [XL-1:0] op_a = '0;
  logic [XL-1:0] op_b = '0;
  logic [4:0]    op_code = '0;
  logic [XL-1:0] result;
  logic [2:0]    flags;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  int_alu #(.XLEN(XL)) u_int_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .op_code(op_code), .result(result), .flags(flags)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [63:0] ref64(logic [63:0] a, logic [63:0] b, logic [4:0] c);
    logic [5:0] s = b[5:0];
    case (c[2:0])
      3'd0: return c[3] ? a - b : a + b;
      3'd1: return a << s;
      3'd2: return {63'd0, $signed(a) < $signed(b)};
      3'd3: return {63'd0, a < b};
      3'd4: return a ^ b;
      3'd5: return c[3] ? 64'($signed(a) >>> s) : a >> s;
      3'd6: return c[3] ? b : a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic [31:0] ref32(logic [31:0] a, logic [31:0] b, logic [4:0] c);
    logic [4:0] s = b[4:0];
    case (c[2:0])
      3'd0: return c[3] ? a - b : a + b;
      3'd1: return a << s;
      3'd2: return {31'd0, $signed(a) < $signed(b)};
      3'd3: return {31'd0, a < b};
      3'd4: return a ^ b;
      3'd5: return c[3] ? 32'($signed(a) >>> s) : a >> s;
      3'd6: return c[3] ? b : a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic [63:0] ref_alu(logic [63:0] a, logic [63:0] b, logic [4:0] c);
    logic [31:0] w;
    if (c[4]) begin
      w = ref32(a[31:0], b[31:0], c);
      return {{32{w[31]}}, w};
    end
    return ref64(a, b, c);
  endfunction

  function automatic logic [2:0] ref_flags(logic [63:0] a, logic [63:0] b);
    return {a == b, $signed(a) < $signed(b), a < b};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // drive on falling edge, sample on the following falling edge
  task automatic apply(logic [63:0] a, logic [63:0] b, logic [4:0] c);
    @(negedge clk);
    op_a = a; op_b = b; op_code = c;
    @(negedge clk);
  endtask

  task automatic run_op(string tag, logic [63:0] a, logic [63:0] b, logic [4:0] c);
    apply(a, b, c);
    check(tag, result, ref_alu(a, b, c));
  endtask

  task automatic t_reset;
    op_a = 64'hFFFF; op_b = 64'h1; op_code = 5'b00000;
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R9 result after reset", result, 64'd0);
    check("R9 flags after reset", {61'd0, flags}, 64'd0);
    rst = 1'b0;
  endtask

  task automatic t_add_sub;
    run_op("R1 add", 64'd5, 64'd7, 5'b00000);
    check("R1 add literal", result, 64'd12);
    run_op("R1 add wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 5'b00000);
    check("R1 add wrap literal", result, 64'd1);
    run_op("R2 sub", 64'd3, 64'd5, 5'b01000);
    check("R2 sub literal", result, 64'hFFFF_FFFF_FFFF_FFFE);
  endtask

  task automatic t_passb;
    run_op("R3 pass-B", 64'h1234_0000_0000_0000, 64'hDEAD_BEEF_0000_1000, 5'b01110);
    check("R3 pass-B literal", result, 64'hDEAD_BEEF_0000_1000);
  endtask

  task automatic t_shifts;
    run_op("R4 sll", 64'h1, 64'd63, 5'b00001);
    check("R4 sll literal", result, 64'h8000_0000_0000_0000);
    run_op("R4 sll mask", 64'h1, 64'd65, 5'b00001);
    check("R4 sll amount masked", result, 64'h2);
    run_op("R4 srl", 64'h8000_0000_0000_0000, 64'd4, 5'b00101);
    check("R4 srl literal", result, 64'h0800_0000_0000_0000);
    run_op("R4 sra", 64'h8000_0000_0000_0000, 64'd4, 5'b01101);
    check("R4 sra literal", result, 64'hF800_0000_0000_0000);
  endtask

  task automatic t_slt;
    run_op("R5 slt neg<pos", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b01010);
    check("R5 slt literal", result, 64'd1);
    run_op("R5 sltu big<1", 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b01011);
    check("R5 sltu literal", result, 64'd0);
    run_op("R5 sltu 0<1", 64'd0, 64'd1, 5'b01011);
    check("R5 sltu true literal", result, 64'd1);
  endtask

  task automatic t_logic;
    run_op("R6 xor", 64'hF0F0, 64'hFF00, 5'b00100);
    check("R6 xor literal", result, 64'h0FF0);
    run_op("R6 or", 64'hF0F0, 64'hFF00, 5'b00110);
    check("R6 or literal", result, 64'hFFF0);
    run_op("R6 and", 64'hF0F0, 64'hFF00, 5'b00111);
    check("R6 and literal", result, 64'hF000);
  endtask

  task automatic t_word;
    run_op("R7 addw", 64'h0000_0001_7FFF_FFFF, 64'd1, 5'b10000);
    check("R7 addw sext", result, 64'hFFFF_FFFF_8000_0000);
    run_op("R7 sllw mask", 64'h1, 64'd33, 5'b10001);
    check("R7 sllw amount 5 bits", result, 64'h2);
    run_op("R7 sraw", 64'h0000_0000_8000_0000, 64'd4, 5'b11101);
    check("R7 sraw literal", result, 64'hFFFF_FFFF_F800_0000);
    run_op("R7 srlw", 64'hFFFF_FFFF_8000_0000, 64'd1, 5'b10101);
    check("R7 srlw literal", result, 64'h0000_0000_4000_0000);
  endtask

  task automatic t_flags;
    apply(64'd9, 64'd9, 5'b00111);
    check("R8 flags equal", {61'd0, flags}, 64'b100);
    apply(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b01110);
    check("R8 flags neg vs 1", {61'd0, flags}, 64'b010);
    apply(64'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'b10000);
    check("R8 flags 1 vs neg word op", {61'd0, flags}, 64'b001);
    apply(64'h1_0000_0000, 64'h0, 5'b10100);
    check("R8 flags use full width", {61'd0, flags}, 64'b000);
  endtask

  task automatic t_alt_ignored;
    logic [2:0] f3s [5] = '{3'b001, 3'b010, 3'b011, 3'b100, 3'b111};
    for (int i = 0; i < 5; i++) begin
      apply(64'h8000_0000_0000_F00D, 64'hFFFF_0000_0000_0003, {2'b01, f3s[i]});
      check("R10 alt ignored", result, ref64(64'h8000_0000_0000_F00D, 64'hFFFF_0000_0000_0003, {2'b00, f3s[i]}));
    end
  endtask

  task automatic t_random;
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      logic [4:0]  c;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (i % 4 == 0) b = a;
      if (i % 7 == 0) b = {58'd0, b[5:0]};
      c = 5'($urandom);
      apply(a, b, c);
      check("R1-R8 random result", result, ref_alu(a, b, c));
      check("R8 random flags", {61'd0, flags}, {61'd0, ref_flags(a, b)});
    end
  endtask

  initial begin
    t_reset();
    t_add_sub();
    t_passb();
    t_shifts();
    t_slt();
    t_logic();
    t_word();
    t_flags();
    t_alt_ignored();
    t_random();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule